// File: doc/BRIEF.md
# Character-Grid Video Timing and Address Generator

This block drives a 640×480 text display built from 8×8 character cells. A horizontal pixel counter and a line counter step through an 800-clock line and a 525-line field. From them the block derives active-low horizontal and vertical sync pulses, a blanking flag and a byte address into character memory. Each byte of that memory holds one character code.

The character address steps by one for every eight visible pixels. When a line ends, the address goes back to the first character of the current text row. This repeats for eight scanlines, and only then does the row base move forward by one row of 80 characters. Alongside the address the block outputs two 3-bit indices, the pixel within the cell and the scanline within the cell, which a downstream font lookup uses to select one glyph bit.

Every output comes from a register, so all outputs describe the same pixel position in the same cycle. The timing widths are parameters, and the defaults give the standard 640×480 mode.

Top module: `text_vid_timing`

## Requirements
- R1: While `rst_n` is low, and in the cycle reset is released, the outputs describe pixel 0 of line 0: `hsync_n`=1, `vsync_n`=1, `blank`=0, `char_addr`=0, `glyph_col`=0, `glyph_row`=0.
- R2: The position advances one pixel per clock. A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (default 800) and a field lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 525). Both counters wrap to 0.
- R3: `hsync_n` is 0 exactly when the pixel index h satisfies H_VIS+H_FP ≤ h < H_VIS+H_FP+H_SYNC (default 656..751).
- R4: `vsync_n` is 0 for whole lines exactly when the line index v satisfies V_VIS+V_FP ≤ v < V_VIS+V_FP+V_SYNC (default 490..491).
- R5: `blank` is 1 exactly when h ≥ H_VIS or v ≥ V_VIS, so it encloses both sync pulses.
- R6: `glyph_col` equals h mod 8 and `glyph_row` equals v mod 8.
- R7: At a visible pixel, `char_addr` = (v div 8)·(H_VIS/8) + (h div 8). The same addresses therefore repeat on the eight lines of a text row.
- R8: `char_addr` holds during blanking. During horizontal blanking of a visible line it stays at the row's last character, (v div 8)·(H_VIS/8) + H_VIS/8 − 1. During vertical blanking it stays at the last cell of the screen, (H_VIS/8)·(V_VIS/8) − 1.
- R9: `char_addr` returns to 0 at the first pixel of every field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| char_addr | output | ADDR_W | Character memory byte address (13 bits by default) |
| glyph_col | output | 3 | Pixel column inside the character cell |
| glyph_row | output | 3 | Scanline inside the character cell |

## Verification
The bench concentrates on the seams of the address sequence. The first of these is the eighth scanline of a text row, where the base moves forward. A design that advanced on the wrong line, or on every line, would show shifted or smeared text rows. The second is the step from the last visible pixel into horizontal blanking, where a design that kept counting would start the next row at the wrong address. The third is the wrap into a new field, where a missing clear would make the picture roll. Random resets in the middle of a field check that the counters and the saved row base restart together, so that no stale base survives. A second instance with the default parameters confirms the standard sync and blanking positions over the first text rows.

// File: rtl/text_vid_timing.sv
module text_vid_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int COLS   = H_VIS / 8,
  localparam int ROWS   = V_VIS / 8,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic [ADDR_W-1:0] char_addr,
  output logic [2:0]        glyph_col,
  output logic [2:0]        glyph_row
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_VEND = HW'(H_VIS);
  localparam logic [VW-1:0] V_VEND = VW'(V_VIS);
  localparam logic [HW-1:0] HS_ON  = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_OFF = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_ON  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_OFF = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(COLS);

  logic [HW-1:0]     hcnt, hnxt;
  logic [VW-1:0]     vcnt, vnxt;
  logic [ADDR_W-1:0] base_q, base_d, addr_d;

  assign hnxt = (hcnt == H_LAST) ? '0 : hcnt + 1'b1;
  assign vnxt = (hcnt != H_LAST) ? vcnt : (vcnt == V_LAST) ? '0 : vcnt + 1'b1;

  always_comb begin
    base_d = base_q;
    addr_d = char_addr;
    if (hnxt == '0) begin
      if (vnxt == '0) begin
        base_d = '0;
        addr_d = '0;
      end else if (vnxt < V_VEND) begin
        if (vcnt[2:0] == 3'd7) base_d = base_q + ROW_STEP;
        addr_d = base_d;
      end
    end else if (vnxt < V_VEND && hnxt < H_VEND && hnxt[2:0] == 3'd0) begin
      addr_d = char_addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      base_q    <= '0;
      char_addr <= '0;
      hsync_n   <= 1'b1;
      vsync_n   <= 1'b1;
      blank     <= 1'b0;
      glyph_col <= 3'd0;
      glyph_row <= 3'd0;
    end else begin
      hcnt      <= hnxt;
      vcnt      <= vnxt;
      base_q    <= base_d;
      char_addr <= addr_d;
      hsync_n   <= !(hnxt >= HS_ON && hnxt < HS_OFF);
      vsync_n   <= !(vnxt >= VS_ON && vnxt < VS_OFF);
      blank     <= (hnxt >= H_VEND) || (vnxt >= V_VEND);
      glyph_col <= hnxt[2:0];
      glyph_row <= vnxt[2:0];
    end
  end
endmodule

module text_vid_timing_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blank,
  input logic [AW-1:0] char_addr,
  input logic [2:0]    glyph_col,
  input logic [2:0]    glyph_row
);
  // R5
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> blank);
  // R5
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> blank);
  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> glyph_col == $past(glyph_col) + 3'd1);
  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_col != 3'd7 |=> $stable(glyph_row));
  // R7
  addr_cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && glyph_col != 3'd0) |-> $stable(char_addr));
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && glyph_col == 3'd7) |=> (blank || char_addr == $past(char_addr) + 1'b1));
  // R8
  addr_blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (!blank || $stable(char_addr)));
endmodule

bind text_vid_timing text_vid_timing_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .blank(blank), .char_addr(char_addr), .glyph_col(glyph_col), .glyph_row(glyph_row)
);

// File: tb/text_vid_timing_test.sv
`timescale 1ns/1ps
module text_vid_timing_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_d_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       hs_s, vs_s, bl_s;
  logic [4:0] ad_s;
  logic [2:0] co_s, ro_s;
  logic       hs_d, vs_d, bl_d;
  logic [12:0] ad_d;
  logic [2:0] co_d, ro_d;

  // small geometry: 80 clocks per line, 30 lines per field
  text_vid_timing #(.H_VIS(64), .H_FP(4), .H_SYNC(8), .H_BP(4),
                    .V_VIS(24), .V_FP(2), .V_SYNC(2), .V_BP(2)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hs_s), .vsync_n(vs_s), .blank(bl_s),
    .char_addr(ad_s), .glyph_col(co_s), .glyph_row(ro_s));

  text_vid_timing uut_dflt (
    .clk(clk), .rst_n(rst_d_n), .hsync_n(hs_d), .vsync_n(vs_d), .blank(bl_d),
    .char_addr(ad_d), .glyph_col(co_d), .glyph_row(ro_d));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(int h, int v, int hv, int vv);
    int cols = hv / 8;
    if (v >= vv) return cols * (vv / 8) - 1;
    if (h >= hv) return (v / 8) * cols + cols - 1;
    return (v / 8) * cols + h / 8;
  endfunction

  task automatic check_pos(input string who, input int h, input int v,
                           input int hv, input int hf, input int hsw,
                           input int vv, input int vf, input int vsw,
                           input logic hs, input logic vs, input logic bl,
                           input int ad, input logic [2:0] co, input logic [2:0] ro);
    chk({who, " R3 hsync_n"}, int'(hs), (h >= hv + hf && h < hv + hf + hsw) ? 0 : 1);
    chk({who, " R4 vsync_n"}, int'(vs), (v >= vv + vf && v < vv + vf + vsw) ? 0 : 1);
    chk({who, " R5 blank"}, int'(bl), (h >= hv || v >= vv) ? 1 : 0);
    chk({who, " R6 glyph_col"}, int'(co), h % 8);
    chk({who, " R6 glyph_row"}, int'(ro), v % 8);
    if (h == 0 && v == 0) chk({who, " R9 field start addr"}, ad, 0);
    else if (h >= hv || v >= vv) chk({who, " R8 blank addr"}, ad, exp_addr(h, v, hv, vv));
    else chk({who, " R7 visible addr"}, ad, exp_addr(h, v, hv, vv));
  endtask

  initial begin
    int hs = 0, vs = 0, hd = 0, vd = 0;
    int r_start[3];
    int r_len[3];
    int last_hfall = -1, last_vfall = -1;
    logic prev_hs = 1'b1, prev_vs = 1'b1;
    logic rst_at_edge;
    void'($urandom(32'd4242));
    r_start[0] = 2399;  r_len[0] = 1;
    r_start[1] = int'($urandom_range(3000, 6000)); r_len[1] = int'($urandom_range(1, 4));
    r_start[2] = int'($urandom_range(7000, 10000)); r_len[2] = int'($urandom_range(1, 4));

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 while held in reset
    chk("R1 reset hsync_n", int'(hs_s), 1);
    chk("R1 reset vsync_n", int'(vs_s), 1);
    chk("R1 reset blank", int'(bl_s), 0);
    chk("R1 reset addr", int'(ad_s), 0);
    chk("R1 reset col", int'(co_s), 0);
    chk("R1 reset row", int'(ro_s), 0);
    chk("R1 reset dflt addr", int'(ad_d), 0);
    rst_n = 1'b1;
    rst_d_n = 1'b1;
    check_pos("R1 small", 0, 0, 64, 4, 8, 24, 2, 2, hs_s, vs_s, bl_s, int'(ad_s), co_s, ro_s);

    for (int n = 0; n < 13600; n++) begin
      rst_at_edge = rst_n;
      @(posedge clk);
      @(negedge clk);
      if (!rst_at_edge) begin hs = 0; vs = 0; last_hfall = -1; last_vfall = -1; end
      else begin
        hs = (hs == 79) ? 0 : hs + 1;
        if (hs == 0) vs = (vs == 29) ? 0 : vs + 1;
      end
      hd = (hd == 799) ? 0 : hd + 1;
      if (hd == 0) vd = (vd == 524) ? 0 : vd + 1;

      if (!rst_n) begin
        chk("R1 mid reset addr", int'(ad_s), 0);
        chk("R1 mid reset blank", int'(bl_s), 0);
        chk("R1 mid reset hsync_n", int'(hs_s), 1);
      end else begin
        check_pos("small", hs, vs, 64, 4, 8, 24, 2, 2, hs_s, vs_s, bl_s, int'(ad_s), co_s, ro_s);
        // R2 line and field periods seen at the sync outputs
        if (prev_hs && !hs_s) begin
          if (last_hfall >= 0) chk("R2 line period", n - last_hfall, 80);
          last_hfall = n;
        end
        if (prev_vs && !vs_s) begin
          if (last_vfall >= 0) chk("R2 field period", n - last_vfall, 2400);
          last_vfall = n;
        end
      end
      prev_hs = hs_s;
      prev_vs = vs_s;
      check_pos("dflt", hd, vd, 640, 16, 96, 480, 10, 2, hs_d, vs_d, bl_d, int'(ad_d), co_d, ro_d);

      rst_n = 1'b1;
      for (int k = 0; k < 3; k++)
        if (n >= r_start[k] && n < r_start[k] + r_len[k]) rst_n = 1'b0;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule